// File: doc/BRIEF.md
# Scan-Shared Port GPIO Register

This block is a test data register that lets the pins of a local scan port serve as general-purpose I/O. A separate TAP controller supplies its state as a set of one-cycle strobes (capture, update) and a shift level. It also supplies two decoded instruction selects: one points the data path at an 8-bit configuration register, the other at an 8-bit pin register. Each register is written by a full capture, shift and update sequence.

When the configuration register holds exactly 0x01, the port runs in shared mode. The port's data-out and mode-select pins then become driven outputs, and its data-in pin is read as an input. The pin register drives the two outputs. New values reach the pins only when the update strobe arrives. Every capture of the pin register samples the live pad levels into its three low bits. A go-to-wait or soft-reset instruction clears both registers, and so does the asynchronous test reset. The port then returns to normal scan use.

Top module: `scan_gpio_share`

## Requirements
- R1: While `rstN` is low, and after it rises, both output enables and both output values are 0. A capture of the configuration register then reads back 0x00.
- R2: A capture with `selMode` high loads the current configuration value into the shift register. It is shifted out LSB first on `scanOut`, one bit per shift cycle.
- R3: `tdoPinOe` and `tmsPinOe` are both 1 exactly when the configuration register holds 0x01. Any other value, such as 0x03, keeps both at 0.
- R4: During shifting and before the update strobe, the output values and enables keep their previous levels.
- R5: A capture with `selGpio` high loads {5'b0, tdiPinIn, tdoPinIn, tmsPinIn}. The data-in level goes to bit 2, the data-out level to bit 1 and the mode-select level to bit 0.
- R6: At update with `selGpio` high, bit 1 of the shifted word sets `tdoPinOut` and bit 0 sets `tmsPinOut`. Bits 7..2 have no effect on the pins or on later readback.
- R7: A one-cycle `goWait` pulse clears the configuration and pin registers, so both outputs and enables go to 0.
- R8: An update with neither select high changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rstN | input | 1 | Asynchronous test reset, active low |
| selMode | input | 1 | Instruction select: configuration register |
| selGpio | input | 1 | Instruction select: pin register |
| captureDr | input | 1 | TAP in Capture-DR (one cycle) |
| shiftDr | input | 1 | TAP in Shift-DR |
| updateDr | input | 1 | TAP in Update-DR (one cycle) |
| goWait | input | 1 | Wait or soft-reset instruction strobe |
| scanIn | input | 1 | Serial data in |
| scanOut | output | 1 | Serial data out (shift register LSB) |
| tdiPinIn | input | 1 | Pad level of the port data-in pin |
| tdoPinIn | input | 1 | Pad level of the port data-out pin |
| tmsPinIn | input | 1 | Pad level of the port mode-select pin |
| tdoPinOut | output | 1 | Value driven on the port data-out pin |
| tdoPinOe | output | 1 | Output enable for the port data-out pin |
| tmsPinOut | output | 1 | Value driven on the port mode-select pin |
| tmsPinOe | output | 1 | Output enable for the port mode-select pin |

## Verification
The assertions assume the TAP decode is well formed. The capture and update strobes each last one cycle, they never coincide with shifting, and at most one instruction select is high at a time. The bench drives every scan as an explicit capture, eight shift cycles and one update. It changes the selects only between scans. It models the pads so that an enabled output loops its own value back to the matching pad input. The assertions that relate pad levels to capture therefore see the levels that the design itself drives.

// File: rtl/scan_gpio_pkg.sv
package scan_gpio_pkg;
  typedef struct packed {
    logic capMode;
    logic capGpio;
    logic shiftEn;
    logic updMode;
    logic updGpio;
    logic clear;
  } ctrlStrobes_t;
endpackage

// File: rtl/scan_gpio_ctrl.sv
module scan_gpio_ctrl
  import scan_gpio_pkg::*;
(
  input  logic         selMode,
  input  logic         selGpio,
  input  logic         captureDr,
  input  logic         shiftDr,
  input  logic         updateDr,
  input  logic         goWait,
  output ctrlStrobes_t strobes
);
  logic gpioPick;
  assign gpioPick = selGpio && !selMode;

  always_comb begin
    strobes.capMode = captureDr && selMode;
    strobes.capGpio = captureDr && gpioPick;
    strobes.shiftEn = shiftDr && (selMode || selGpio);
    strobes.updMode = updateDr && selMode && !goWait;
    strobes.updGpio = updateDr && gpioPick && !goWait;
    strobes.clear   = goWait;
  end
endmodule

// File: rtl/scan_gpio_dp.sv
module scan_gpio_dp
  import scan_gpio_pkg::*;
#(
  parameter int REG_W       = 8,
  parameter int ENABLE_CODE = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strobes,
  input  logic         scanIn,
  output logic         scanOut,
  input  logic         tdiPinIn,
  input  logic         tdoPinIn,
  input  logic         tmsPinIn,
  output logic         tdoPinOut,
  output logic         tdoPinOe,
  output logic         tmsPinOut,
  output logic         tmsPinOe
);
  localparam int PIN_BITS = 3;
  localparam int OUT_BITS = 2;
  localparam int PAD_W    = REG_W - PIN_BITS;
  localparam logic [REG_W-1:0] ENABLE_VAL = REG_W'(ENABLE_CODE);

  logic [REG_W-1:0]    shiftReg;
  logic [REG_W-1:0]    modeReg;
  logic [OUT_BITS-1:0] gpioReg;
  logic [PIN_BITS-1:0] padSample;
  logic                sharedOn;

  assign padSample = {tdiPinIn, tdoPinIn, tmsPinIn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobes.capMode) begin
      shiftReg <= modeReg;
    end else if (strobes.capGpio) begin
      shiftReg <= {{PAD_W{1'b0}}, padSample};
    end else if (strobes.shiftEn) begin
      shiftReg <= {scanIn, shiftReg[REG_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= '0;
      gpioReg <= '0;
    end else if (strobes.clear) begin
      modeReg <= '0;
      gpioReg <= '0;
    end else begin
      if (strobes.updMode) modeReg <= shiftReg;
      if (strobes.updGpio) gpioReg <= shiftReg[OUT_BITS-1:0];
    end
  end

  assign sharedOn = (modeReg == ENABLE_VAL);
  assign scanOut  = shiftReg[0];

  logic [OUT_BITS-1:0] outVal;
  logic [OUT_BITS-1:0] outEn;
  for (genvar g = 0; g < OUT_BITS; g++) begin : g_outPin
    assign outVal[g] = gpioReg[g];
    assign outEn[g]  = sharedOn;
  end

  assign tdoPinOut = outVal[1];
  assign tdoPinOe  = outEn[1];
  assign tmsPinOut = outVal[0];
  assign tmsPinOe  = outEn[0];
endmodule

// File: rtl/scan_gpio_share.sv
module scan_gpio_share
  import scan_gpio_pkg::*;
#(
  parameter int REG_W       = 8,
  parameter int ENABLE_CODE = 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic selMode,
  input  logic selGpio,
  input  logic captureDr,
  input  logic shiftDr,
  input  logic updateDr,
  input  logic goWait,
  input  logic scanIn,
  output logic scanOut,
  input  logic tdiPinIn,
  input  logic tdoPinIn,
  input  logic tmsPinIn,
  output logic tdoPinOut,
  output logic tdoPinOe,
  output logic tmsPinOut,
  output logic tmsPinOe
);
  ctrlStrobes_t strobes;

  scan_gpio_ctrl u_ctrl (
    .selMode(selMode), .selGpio(selGpio), .captureDr(captureDr),
    .shiftDr(shiftDr), .updateDr(updateDr), .goWait(goWait),
    .strobes(strobes)
  );

  scan_gpio_dp #(.REG_W(REG_W), .ENABLE_CODE(ENABLE_CODE)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .scanIn(scanIn),
    .scanOut(scanOut), .tdiPinIn(tdiPinIn), .tdoPinIn(tdoPinIn),
    .tmsPinIn(tmsPinIn), .tdoPinOut(tdoPinOut), .tdoPinOe(tdoPinOe),
    .tmsPinOut(tmsPinOut), .tmsPinOe(tmsPinOe)
  );
endmodule

// File: rtl/scan_gpio_share_chk.sv
module scan_gpio_share_chk (
  input logic clk,
  input logic rstN,
  input logic selMode,
  input logic selGpio,
  input logic captureDr,
  input logic updateDr,
  input logic goWait,
  input logic scanOut,
  input logic tmsPinIn,
  input logic tdoPinOut,
  input logic tdoPinOe,
  input logic tmsPinOut,
  input logic tmsPinOe
);
  always @(posedge clk) begin
    if (!rstN) begin
      a_reset_quiet_r1: assert (!tdoPinOe && !tmsPinOe && !tdoPinOut && !tmsPinOut)
        else $error("outputs active during reset");
    end
  end

  p_oe_pair_r3: assert property (@(posedge clk) disable iff (!rstN)
    tdoPinOe == tmsPinOe);

  p_oe_rise_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tdoPinOe) |-> $past(updateDr && selMode));

  p_hold_until_update_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(updateDr) && !$past(goWait)) |->
      ($stable(tdoPinOut) && $stable(tmsPinOut) && $stable(tdoPinOe)));

  p_capture_bit0_r5: assert property (@(posedge clk) disable iff (!rstN)
    (captureDr && selGpio && !selMode) |=> (scanOut == $past(tmsPinIn)));

  p_wait_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    goWait |=> (!tdoPinOe && !tmsPinOe && !tdoPinOut && !tmsPinOut));
endmodule

bind scan_gpio_share scan_gpio_share_chk u_chk (
  .clk(clk), .rstN(rstN), .selMode(selMode), .selGpio(selGpio),
  .captureDr(captureDr), .updateDr(updateDr), .goWait(goWait),
  .scanOut(scanOut), .tmsPinIn(tmsPinIn), .tdoPinOut(tdoPinOut),
  .tdoPinOe(tdoPinOe), .tmsPinOut(tmsPinOut), .tmsPinOe(tmsPinOe)
);

// File: tb/scan_gpio_share_bench.sv
module scan_gpio_share_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic selMode = 0, selGpio = 0, captureDr = 0, shiftDr = 0, updateDr = 0;
  logic goWait = 0, scanIn = 0;
  logic extTdi = 0, extTdo = 0, extTms = 0;
  logic scanOut, tdoPinOut, tdoPinOe, tmsPinOut, tmsPinOe;
  logic tdoPad, tmsPad;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  typedef struct {
    logic [7:0] val;
    string      tag;
  } expItem_t;
  expItem_t   expQ[$];
  logic [7:0] gotByte;
  event       scanDone;

  always #5 clk = ~clk;

  assign tdoPad = tdoPinOe ? tdoPinOut : extTdo;
  assign tmsPad = tmsPinOe ? tmsPinOut : extTms;

  scan_gpio_share u_scan_gpio_share (
    .clk(clk), .rstN(rstN), .selMode(selMode), .selGpio(selGpio),
    .captureDr(captureDr), .shiftDr(shiftDr), .updateDr(updateDr),
    .goWait(goWait), .scanIn(scanIn), .scanOut(scanOut),
    .tdiPinIn(extTdi), .tdoPinIn(tdoPad), .tmsPinIn(tmsPad),
    .tdoPinOut(tdoPinOut), .tdoPinOe(tdoPinOe),
    .tmsPinOut(tmsPinOut), .tmsPinOe(tmsPinOe)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic checkPins(input string tag, input logic [3:0] exp);
    check(tag, {4'h0, tdoPinOe, tmsPinOe, tdoPinOut, tmsPinOut}, {4'h0, exp});
  endtask

  // sel: 0 none, 1 config, 2 pin register; hold >= 0 checks pins before update
  task automatic scan(input int sel, input logic [7:0] wd, input logic [7:0] expRd,
                      input string tag, input int hold);
    logic [7:0] rd;
    if (sel != 0) begin
      expItem_t e;
      e.val = expRd;
      e.tag = tag;
      expQ.push_back(e);
    end
    @(negedge clk);
    selMode = (sel == 1);
    selGpio = (sel == 2);
    captureDr = 1;
    @(negedge clk);
    captureDr = 0;
    shiftDr = 1;
    for (int i = 0; i < 8; i++) begin
      scanIn = wd[i];
      rd[i] = scanOut;
      @(negedge clk);
    end
    shiftDr = 0;
    if (hold >= 0) checkPins("R4 hold before update", 4'(hold));
    updateDr = 1;
    @(negedge clk);
    updateDr = 0;
    selMode = 0;
    selGpio = 0;
    if (sel != 0) begin
      gotByte = rd;
      -> scanDone;
    end
  endtask

  initial begin : monitor
    forever begin
      @(scanDone);
      if (expQ.size() == 0) begin
        check("scoreboard underflow", gotByte, 8'hxx);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check(e.tag, gotByte, e.val);
      end
    end
  end

  initial begin : watchdog
    #200000;
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin : stim
    #1;
    checkPins("R1 during reset", 4'b0000);
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    checkPins("R1 after reset", 4'b0000);
    scan(1, 8'h00, 8'h00, "R1 config reads 00 after reset", -1);

    extTdi = 1; extTdo = 0; extTms = 1;
    scan(2, 8'h03, 8'h05, "R5 capture pads 1,0,1", -1);
    check("R3 off with config 00", {7'h0, tdoPinOe}, 8'h00);

    scan(1, 8'h03, 8'h00, "R2 config readback 00", -1);
    check("R3 off with config 03", {6'h0, tdoPinOe, tmsPinOe}, 8'h00);
    scan(1, 8'h01, 8'h03, "R2 config readback 03", -1);
    checkPins("R3 on with config 01, R6 pins 11", 4'b1111);

    extTdi = 0;
    scan(2, 8'h00, 8'h03, "R5 capture driven 1,1 tdi 0", 4'b1111);
    checkPins("R6 write 00", 4'b1100);

    extTdi = 1;
    scan(2, 8'hFE, 8'h04, "R5 capture driven 0,0 tdi 1", 4'b1100);
    checkPins("R6 write FE upper ignored", 4'b1110);
    scan(2, 8'h01, 8'h06, "R6 upper bits not read back", 4'b1110);
    checkPins("R6 write 01", 4'b1101);

    scan(0, 8'h00, 8'h00, "", 4'b1101);
    checkPins("R8 no select keeps pins", 4'b1101);
    scan(1, 8'h01, 8'h01, "R8 config unchanged", -1);

    @(negedge clk); goWait = 1;
    @(negedge clk); goWait = 0;
    checkPins("R7 wait clears pins", 4'b0000);
    scan(1, 8'h01, 8'h00, "R7 config cleared", -1);
    checkPins("R3 re-enabled", 4'b1100);
    scan(2, 8'h03, 8'h04, "R7 pin reg cleared", -1);
    checkPins("R6 drive 11 again", 4'b1111);

    @(negedge clk); rstN = 0;
    #1;
    checkPins("R1 async reset", 4'b0000);
    @(negedge clk); rstN = 1;
    scan(1, 8'h00, 8'h00, "R1 config cleared by reset", -1);

    repeat (2) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule